// File: doc/BRIEF.md
# Complementary Half-Bridge Pulse Generator

This block produces the two gate enables of a half-bridge, one for the low-side switch and one for the high-side switch. It works entirely in cycles of a fast system clock. A switching period has two halves of equal length. The low-side half always comes first, and the high-side half follows it. Each half begins with a guard interval during which both enables are low, and the enable that owns the half is high for the rest of it. Each side therefore holds a 50% share of the period, with its own dead time counted inside that share.

The half-period length and the guard length each come from a control word. Both words are bounded before use. The half period has a floor, which caps the switching frequency. The guard has a floor and a ceiling, and it is also kept shorter than the half period. Both bounded values are captured only when a new period starts.

A digital level code is compared against two thresholds. The comparison sets a skip state with hysteresis, which suspends switching at light load. An enable input from protection logic also stops switching. Neither stop request shortens a pulse: switching halts only at the end of the half period in progress.

Top module: `hb_pulse_gen`

## Requirements
- R1: While reset is asserted, and afterwards for as long as `en_i` stays low, both `ls_on_o` and `hs_on_o` are low.
- R2: During switching, a low-side half of H cycles is followed by a high-side half of H cycles. In each half, both outputs are low for the first D cycles, and then the owning output is high for H−D cycles.
- R3: `ls_on_o` and `hs_on_o` are never high in the same clock cycle.
- R4: The half length H equals `half_word_i`, raised to MIN_HALF when the word is smaller. This sets the highest switching frequency.
- R5: The guard length D equals `dt_word_i` bounded to the range DT_MIN..DT_MAX, so a zero word gives DT_MIN and an all-ones word gives DT_MAX. D is further lowered to H−1 whenever it would reach H.
- R6: Both words are captured only when a low-side half begins. A change in either word during a period has no effect until the next period.
- R7: The skip state is set one cycle after `lvl_i` < `thr_lo_i`. It is cleared one cycle after `lvl_i` > `thr_hi_i`. While `thr_lo_i` ≤ `lvl_i` ≤ `thr_hi_i`, including equality with either threshold, the state is held.
- R8: A skip request arriving during a half lets that half finish with its full-width pulse. Both outputs then stay low.
- R9: When switching resumes from rest, it starts with a low-side half whose guard comes first. The low-side output rises D+2 cycles after the level input crosses above the upper threshold.
- R10: Dropping `en_i` stops switching at the end of the current half, without shortening the pulse in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Switching permission from protection logic |
| half_word_i | input | HALF_W | Requested half-period length in clock cycles |
| dt_word_i | input | DT_W | Requested guard length in clock cycles |
| lvl_i | input | LVL_W | Control level code for pulse skipping |
| thr_lo_i | input | LVL_W | Level below which skipping begins |
| thr_hi_i | input | LVL_W | Level above which skipping ends |
| ls_on_o | output | 1 | Low-side gate enable |
| hs_on_o | output | 1 | High-side gate enable |

## Verification
The bench builds the block with HALF_W=8, DT_W=6, MIN_HALF=10, DT_MIN=2 and DT_MAX=12. With these values, both guard bounds and the half-period floor are reached within a few tens of cycles. Because DT_MAX exceeds MIN_HALF−1, the case where the guard must be trimmed below the half period also becomes reachable, leaving a one-cycle pulse. These short periods let the bench cover the following in a few thousand cycles:
- a word changed in mid-period;
- skip entry, hold and exit;
- the exact restart latency.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    PH_REST = 2'd0,
    PH_LS   = 2'd1,
    PH_HS   = 2'd2
  } hb_phase_e;
endpackage

// File: rtl/hb_skip_gate.sv
module hb_skip_gate #(
  parameter int LVL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0] thr_lo_i,
  input  logic [LVL_W-1:0] thr_hi_i,
  output logic             skip_o
);
  logic skip_q, skip_d;
  logic below_w, above_w;

  assign below_w = (lvl_i < thr_lo_i);
  assign above_w = (lvl_i > thr_hi_i);

  always_comb begin
    skip_d = skip_q;
    if (below_w)      skip_d = 1'b1;
    else if (above_w) skip_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) skip_q <= 1'b0;
    else         skip_q <= skip_d;
  end

  assign skip_o = skip_q;

  // R7
  skip_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i < thr_lo_i) |=> skip_o);
  // R7
  skip_leave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i > thr_hi_i && lvl_i >= thr_lo_i) |=> !skip_o);
  // R7
  skip_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i >= thr_lo_i && lvl_i <= thr_hi_i) |=> $stable(skip_o));
endmodule

// File: rtl/hb_timing_latch.sv
module hb_timing_latch #(
  parameter int HALF_W   = 12,
  parameter int DT_W     = 8,
  parameter int MIN_HALF = 167,
  parameter int DT_MIN   = 10,
  parameter int DT_MAX   = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [HALF_W-1:0] half_word_i,
  input  logic [DT_W-1:0]   dt_word_i,
  output logic [HALF_W-1:0] half_o,
  output logic [HALF_W-1:0] dt_o
);
  localparam logic [HALF_W-1:0] HalfFloor = HALF_W'(MIN_HALF);
  localparam logic [HALF_W-1:0] GuardLo   = HALF_W'(DT_MIN);
  localparam logic [HALF_W-1:0] GuardHi   = HALF_W'(DT_MAX);
  localparam logic [HALF_W-1:0] One       = HALF_W'(1);

  logic [HALF_W-1:0] half_q, dt_q;
  logic [HALF_W-1:0] half_eff, dt_ext, dt_bound, dt_eff;

  always_comb begin
    half_eff = (half_word_i < HalfFloor) ? HalfFloor : half_word_i;
    dt_ext   = HALF_W'(dt_word_i);
    if (dt_ext < GuardLo)      dt_bound = GuardLo;
    else if (dt_ext > GuardHi) dt_bound = GuardHi;
    else                       dt_bound = dt_ext;
    dt_eff = (dt_bound >= half_eff) ? (half_eff - One) : dt_bound;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= HalfFloor;
      dt_q   <= GuardLo;
    end else if (load_i) begin
      half_q <= half_eff;
      dt_q   <= dt_eff;
    end
  end

  assign half_o = half_q;
  assign dt_o   = dt_q;

  // R4
  half_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_q >= HalfFloor);
  // R5
  guard_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dt_q <= GuardHi) && (dt_q < half_q));
  // R6
  capture_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(half_q) && $stable(dt_q)));
endmodule

// File: rtl/hb_phase_seq.sv
module hb_phase_seq
  import hb_pkg::*;
#(
  parameter int HALF_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic [HALF_W-1:0] dt_i,
  output logic              load_o,
  output logic              ls_o,
  output logic              hs_o
);
  localparam logic [HALF_W-1:0] One = HALF_W'(1);

  hb_phase_e         phase_q, phase_d;
  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic              last_w, step_en;

  assign last_w  = (cnt_q == (half_i - One));
  assign step_en = (phase_q != PH_REST) || run_i;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q + One;
    load_o  = 1'b0;
    unique case (phase_q)
      PH_REST: begin
        cnt_d = '0;
        if (run_i) begin
          phase_d = PH_LS;
          load_o  = 1'b1;
        end
      end
      PH_LS: begin
        if (last_w) begin
          cnt_d   = '0;
          phase_d = run_i ? PH_HS : PH_REST;
        end
      end
      PH_HS: begin
        if (last_w) begin
          cnt_d = '0;
          if (run_i) begin
            phase_d = PH_LS;
            load_o  = 1'b1;
          end else begin
            phase_d = PH_REST;
          end
        end
      end
      default: begin
        phase_d = PH_REST;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_REST;
      cnt_q   <= '0;
    end else if (step_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign ls_o = (phase_q == PH_LS) && (cnt_q >= dt_i);
  assign hs_o = (phase_q == PH_HS) && (cnt_q >= dt_i);

  // R3
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ls_o && hs_o));
  // R8
  half_intact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_REST && !last_w) |=> (phase_q == $past(phase_q)));
  // R10
  stop_at_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_REST && last_w && !run_i) |=> (phase_q == PH_REST));
  // R9
  restart_ls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_REST && run_i) |=> (phase_q == PH_LS && cnt_q == '0));
endmodule

// File: rtl/hb_pulse_gen.sv
module hb_pulse_gen #(
  parameter int HALF_W   = 12,
  parameter int DT_W     = 8,
  parameter int LVL_W    = 8,
  parameter int MIN_HALF = 167,
  parameter int DT_MIN   = 10,
  parameter int DT_MAX   = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [HALF_W-1:0] half_word_i,
  input  logic [DT_W-1:0]   dt_word_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic [LVL_W-1:0]  thr_lo_i,
  input  logic [LVL_W-1:0]  thr_hi_i,
  output logic              ls_on_o,
  output logic              hs_on_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic              skip_w, run_w, load_w;
  logic [HALF_W-1:0] half_w, dt_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  hb_skip_gate #(.LVL_W(LVL_W)) u_skip (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .lvl_i    (lvl_i),
    .thr_lo_i (thr_lo_i),
    .thr_hi_i (thr_hi_i),
    .skip_o   (skip_w)
  );

  assign run_w = en_i && !skip_w;

  hb_timing_latch #(
    .HALF_W   (HALF_W),
    .DT_W     (DT_W),
    .MIN_HALF (MIN_HALF),
    .DT_MIN   (DT_MIN),
    .DT_MAX   (DT_MAX)
  ) u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .load_i      (load_w),
    .half_word_i (half_word_i),
    .dt_word_i   (dt_word_i),
    .half_o      (half_w),
    .dt_o        (dt_w)
  );

  hb_phase_seq #(.HALF_W(HALF_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .run_i  (run_w),
    .half_i (half_w),
    .dt_i   (dt_w),
    .load_o (load_w),
    .ls_o   (ls_on_o),
    .hs_o   (hs_on_o)
  );

  // R1
  rest_in_reset_chk: assert property (@(posedge clk_i)
    !rst_n_int |-> (!ls_on_o && !hs_on_o));
endmodule

// File: tb/hb_pulse_gen_bench.sv
`timescale 1ns/1ps
module hb_pulse_gen_bench;
  localparam int HW = 8;
  localparam int DW = 6;
  localparam int LW = 8;
  localparam int NV = 8;
  // half word, guard word, expected H, expected D
  localparam int VEC [NV][4] = '{
    '{20,  4,  20,  4},
    '{ 3,  4,  10,  4},
    '{ 0,  5,  10,  5},
    '{16,  0,  16,  2},
    '{16,  1,  16,  2},
    '{30, 63,  30, 12},
    '{10, 63,  10,  9},
    '{255, 12, 255, 12}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [HW-1:0] half_w = '0;
  logic [DW-1:0] dt_w = '0;
  logic [LW-1:0] lvl = 8'd100;
  logic [LW-1:0] thr_lo = 8'd40;
  logic [LW-1:0] thr_hi = 8'd60;
  logic          ls_on, hs_on;

  int checks = 0;
  int fails = 0;
  int overlaps = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  hb_pulse_gen #(
    .HALF_W(HW), .DT_W(DW), .LVL_W(LW),
    .MIN_HALF(10), .DT_MIN(2), .DT_MAX(12)
  ) u_hb_pulse_gen (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .half_word_i(half_w), .dt_word_i(dt_w),
    .lvl_i(lvl), .thr_lo_i(thr_lo), .thr_hi_i(thr_hi),
    .ls_on_o(ls_on), .hs_on_o(hs_on)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: act=%0d exp<=100000", cyc);
      summary();
      $finish;
    end
  end

  // R3 monitor
  always @(negedge clk) if (ls_on && hs_on) overlaps++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 ls in reset", int'(ls_on), 0);
    check("R1 hs in reset", int'(hs_on), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // kind 0: ls high, 1: hs high, 2: both low
  task automatic run_len(input int kind, output int n);
    n = 0;
    while (n < 1000 && ((kind == 0 && ls_on) || (kind == 1 && hs_on) ||
                        (kind == 2 && !ls_on && !hs_on))) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_first(output int which, output int n);
    n = 0;
    while (n < 2000 && !ls_on && !hs_on) begin
      n++;
      @(negedge clk);
    end
    which = hs_on ? 1 : 0;
  endtask

  task automatic quiet_for(input int cycles, output int highs);
    highs = 0;
    for (int i = 0; i < cycles; i++) begin
      if (ls_on || hs_on) highs++;
      @(negedge clk);
    end
  endtask

  initial begin
    int w, n, a, b, c, d, h, dd;
    @(negedge clk);
    // R1 after release with enable low
    do_reset();
    quiet_for(40, n);
    check("R1 idle while disabled", n, 0);

    // table of vectors: R2 R4 R5 R9
    for (int v = 0; v < NV; v++) begin
      en = 1'b0;
      half_w = HW'(VEC[v][0]);
      dt_w = DW'(VEC[v][1]);
      h = VEC[v][2];
      dd = VEC[v][3];
      do_reset();
      en = 1'b1;
      wait_first(w, n);
      check("R9 low side first", w, 0);
      run_len(0, a);
      run_len(2, b);
      run_len(1, c);
      run_len(2, d);
      check("R2 R4 R5 ls width", a, h - dd);
      check("R2 R5 guard before hs", b, dd);
      check("R2 R4 R5 hs width", c, h - dd);
      check("R2 R5 guard before ls", d, dd);
    end

    // R6: word change mid-period
    en = 1'b0; half_w = 8'd20; dt_w = 6'd4;
    do_reset();
    en = 1'b1;
    wait_first(w, n);
    half_w = 8'd14;
    run_len(0, a); run_len(2, b); run_len(1, c); run_len(2, d);
    check("R6 ls keeps old H", a, 16);
    check("R6 hs keeps old H", c, 16);
    run_len(0, a);
    check("R6 new H next period", a, 10);

    // R7 R8 R9 skip hysteresis
    en = 1'b0; half_w = 8'd20; dt_w = 6'd4; lvl = 8'd100;
    do_reset();
    en = 1'b1;
    wait_first(w, n);
    lvl = 8'd30;
    run_len(0, a);
    check("R8 pulse not truncated by skip", a, 16);
    quiet_for(80, n);
    check("R7 R8 stopped while skipping", n, 0);
    lvl = 8'd50;
    quiet_for(80, n);
    check("R7 held between thresholds", n, 0);
    lvl = 8'd60;
    quiet_for(20, n);
    check("R7 equal to upper threshold holds", n, 0);
    lvl = 8'd70;
    wait_first(w, n);
    check("R9 resume on low side", w, 0);
    check("R7 R9 restart latency", n, 4 + 2);
    run_len(0, a);
    check("R9 first pulse full width", a, 16);
    lvl = 8'd40;
    quiet_for(80, n);
    check("R7 equal to lower threshold keeps running", int'(n > 0), 1);

    // R10 enable drop during high-side pulse
    lvl = 8'd100;
    n = 0;
    while (n < 200 && !hs_on) begin n++; @(negedge clk); end
    en = 1'b0;
    run_len(1, c);
    check("R10 hs pulse completes", c, 16);
    quiet_for(80, n);
    check("R10 stopped after disable", n, 0);
    en = 1'b1;
    wait_first(w, n);
    check("R9 resume after enable", w, 0);
    run_len(0, a);
    check("R10 R2 ls width after resume", a, 16);

    check("R3 no overlap seen", overlaps, 0);
    summary();
    $finish;
  end
endmodule